// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog with an APB register interface. A 32-bit up-counter advances on a tick strobe. The strobe comes either from an internal source or from an external slow-clock source, and both sources are generated outside the block. The counter is compared with a programmable limit. When a tick arrives while the counter already equals the limit, the counter wraps to zero, an overflow flag is raised and a system reset request is driven. An interrupt is also raised when software has enabled it.

Software must write a fixed 32-bit unlock word before every write to a configuration register, so stray writes cannot disable or retune the watchdog. Software keeps the system alive by setting the feed bit. While that bit is 1 the counter is held at zero, and writing the bit back to 0 lets counting resume. Reading the status register clears the overflow flag. The prescaler setting is stored here and driven out to the external tick generator.

Top module: `apb_watchdog`

## Requirements
- R1: PREADY is always 1 and PSLVERR is always 0. A transfer takes effect in its access phase, and only when paddr[1:0] is 0. Reads return the registers at word offsets 0x00 control, 0x04 prescale, 0x08 count, 0x0C limit, 0x10 status, 0x14 key and 0x18 feed. Unused bits and the key register read as 0.
- R2: A write of 0x5F3759DF to offset 0x14 arms the lock for one write. A write of any other value to 0x14 leaves the lock state unchanged.
- R3: The control, prescale, limit and feed registers change only on a write made while the lock is armed. Otherwise the write is ignored.
- R4: Any write to an offset other than 0x14 disarms the lock, including writes to read-only or unmapped offsets.
- R5: After reset, control reads 0, prescale reads 2, and count, limit, status and feed read 0. irq_o and sys_rst_o are low.
- R6: Control bit 2 enables counting. Bit 1 selects the tick source: 1 is tick_ext_i and 0 is tick_int_i. Bit 0 enables the interrupt. The count advances by one on each selected tick while enabled, and it ignores writes.
- R7: A selected tick that arrives while count equals limit sets count to 0 and sets status bit 0. The first overflow after a clear therefore takes limit+1 ticks.
- R8: A read of status returns the flag and clears it, unless an overflow happens in the same cycle. Feeding does not clear the flag.
- R9: While feed bit 0 is 1, count is held at 0 and ticks are ignored. Writing it back to 0 resumes counting from 0.
- R10: irq_o equals the flag AND the interrupt enable, delayed by one clock.
- R11: sys_rst_o rises in the same cycle as the flag. It stays high until a status read, a feed bit of 1 or a cleared enable drops it, one clock later.
- R12: presc_o carries the 20-bit prescale register. Bits above bit 19 are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, constant 1 |
| pslverr | output | 1 | APB error, constant 0 |
| tick_int_i | input | 1 | Internal tick strobe |
| tick_ext_i | input | 1 | External tick strobe |
| presc_o | output | PSC_W | Prescale value for the tick generator |
| irq_o | output | 1 | Overflow interrupt |
| sys_rst_o | output | 1 | System reset request |

## Verification
On every cycle, the assertions check the following:
- lock disarming and the effect of a bad key;
- ignored control writes while locked;
- count stepping, holding and wrapping;
- flag clearing on a status read;
- the feed hold;
- the reset request falling when counting is disabled;
- the interrupt following the enabled flag.

Only the bench scenarios can show the following:
- the overflow arriving after exactly limit+1 ticks;
- the choice between the two tick sources;
- the read-to-clear value seen on the bus;
- masked bits and reset values;
- the reset request surviving until a feed while the flag persists.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [31:0] UNLOCK_WORD = 32'h5F37_59DF;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_PSC  = 'h04;
  localparam int OFF_CNT  = 'h08;
  localparam int OFF_LIM  = 'h0C;
  localparam int OFF_STAT = 'h10;
  localparam int OFF_KEY  = 'h14;
  localparam int OFF_FEED = 'h18;

  localparam int CTRL_W   = 3;
  localparam int B_IE     = 0;
  localparam int B_SRC    = 1;
  localparam int B_EN     = 2;

  typedef struct packed {
    logic en;
    logic src_ext;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/wdg_regfile.sv
module wdg_regfile #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int PSC_W    = 20,
  parameter logic [2:0] CTRL_RST = 3'b000,
  parameter int PSC_RST  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output wdg_pkg::ctrl_t    ctrl_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [CNT_W-1:0]  lim_o,
  output logic              feed_o,
  output logic              stat_rd_o
);
  import wdg_pkg::*;

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(OFF_CTRL >> 2);
  localparam logic [IDX_W-1:0] I_PSC  = IDX_W'(OFF_PSC  >> 2);
  localparam logic [IDX_W-1:0] I_CNT  = IDX_W'(OFF_CNT  >> 2);
  localparam logic [IDX_W-1:0] I_LIM  = IDX_W'(OFF_LIM  >> 2);
  localparam logic [IDX_W-1:0] I_STAT = IDX_W'(OFF_STAT >> 2);
  localparam logic [IDX_W-1:0] I_KEY  = IDX_W'(OFF_KEY  >> 2);
  localparam logic [IDX_W-1:0] I_FEED = IDX_W'(OFF_FEED >> 2);

  logic [IDX_W-1:0] idx;
  logic             aligned, wr, rd, wr_key, armed_q;
  ctrl_t            ctrl_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] lim_q;
  logic             feed_q;

  assign idx     = paddr[ADDR_W-1:2];
  assign aligned = (paddr[1:0] == 2'b00);
  assign wr      = psel & penable & pwrite & aligned;
  assign rd      = psel & penable & ~pwrite & aligned;
  assign wr_key  = wr & (idx == I_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (wr_key) begin
      if (pwdata == UNLOCK_WORD) armed_q <= 1'b1;
    end else if (wr) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= ctrl_t'(CTRL_RST);
      psc_q  <= PSC_W'(PSC_RST);
      lim_q  <= '0;
      feed_q <= 1'b0;
    end else if (wr && armed_q) begin
      case (idx)
        I_CTRL:  ctrl_q <= ctrl_t'(pwdata[CTRL_W-1:0]);
        I_PSC:   psc_q  <= pwdata[PSC_W-1:0];
        I_LIM:   lim_q  <= pwdata[CNT_W-1:0];
        I_FEED:  feed_q <= pwdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    prdata = '0;
    if (aligned) begin
      case (idx)
        I_CTRL:  prdata = DATA_W'(ctrl_q);
        I_PSC:   prdata = DATA_W'(psc_q);
        I_CNT:   prdata = DATA_W'(cnt_i);
        I_LIM:   prdata = DATA_W'(lim_q);
        I_STAT:  prdata = DATA_W'(flag_i);
        I_FEED:  prdata = DATA_W'(feed_q);
        default: prdata = '0;
      endcase
    end
  end

  assign ctrl_o    = ctrl_q;
  assign psc_o     = psc_q;
  assign lim_o     = lim_q;
  assign feed_o    = feed_q;
  assign stat_rd_o = rd & (idx == I_STAT);

  // R3: a control write without the lock armed leaves control untouched
  a_r3_locked_ctrl: assert property (@(posedge clk) disable iff (rst)
    (wr && idx == I_CTRL && !armed_q) |=> $stable(ctrl_q));
  // R4: any write away from the key offset leaves the lock disarmed
  a_r4_lock_spent: assert property (@(posedge clk) disable iff (rst)
    (wr && idx != I_KEY) |=> !armed_q);
  // R2: a wrong key word never arms the lock
  a_r2_bad_key: assert property (@(posedge clk) disable iff (rst)
    (wr_key && pwdata != UNLOCK_WORD && !armed_q) |=> !armed_q);
endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  wdg_pkg::ctrl_t   ctrl_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             feed_i,
  input  logic             stat_rd_i,
  input  logic             tick_int_i,
  input  logic             tick_ext_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             sys_rst_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             tick, adv, hit, ovf;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q, irq_q, rst_q;

  assign tick = ctrl_i.src_ext ? tick_ext_i : tick_int_i;
  assign adv  = ctrl_i.en & tick & ~feed_i;
  assign hit  = (cnt_q == lim_i);
  assign ovf  = adv & hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (feed_i)   cnt_q <= '0;
      else if (adv) cnt_q <= hit ? '0 : cnt_q + ONE;
      flag_q <= ovf | (flag_q & ~stat_rd_i);
      irq_q  <= flag_q & ctrl_i.irq_en;
      rst_q  <= ovf | (rst_q & ~stat_rd_i & ~feed_i & ctrl_i.en);
    end
  end

  assign cnt_o     = cnt_q;
  assign flag_o    = flag_q;
  assign irq_o     = irq_q;
  assign sys_rst_o = rst_q;

  // R9: feed holds the count at zero
  a_r9_feed_hold: assert property (@(posedge clk) disable iff (rst)
    feed_i |=> (cnt_q == '0));
  // R6: an accepted tick below the limit steps by one
  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !hit) |=> (cnt_q == $past(cnt_q) + ONE));
  // R6: disabled and not fed, the count does not move
  a_r6_idle: assert property (@(posedge clk) disable iff (rst)
    (!feed_i && !ctrl_i.en) |=> $stable(cnt_q));
  // R7: overflow wraps the count and raises the flag
  a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt_q == '0 && flag_q));
  // R8: a status read with no new overflow clears the flag
  a_r8_rd_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_i && !ovf) |=> !flag_q);
  // R11: reset request drops once counting is disabled
  a_r11_needs_en: assert property (@(posedge clk) disable iff (rst)
    !ctrl_i.en |=> !rst_q);
endmodule

// File: rtl/apb_watchdog.sv
module apb_watchdog #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 20,
  parameter logic [2:0] CTRL_RST = 3'b000,
  parameter int PSC_RST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              tick_int_i,
  input  logic              tick_ext_i,
  output logic [PSC_W-1:0]  presc_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam int DATA_W = 32;

  wdg_pkg::ctrl_t   ctrl;
  logic [CNT_W-1:0] lim, cnt;
  logic             feed, stat_rd, flag;

  wdg_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W),
    .CTRL_RST(CTRL_RST), .PSC_RST(PSC_RST)
  ) i_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .cnt_i(cnt), .flag_i(flag), .ctrl_o(ctrl), .psc_o(presc_o),
    .lim_o(lim), .feed_o(feed), .stat_rd_o(stat_rd)
  );

  wdg_core #(.CNT_W(CNT_W)) i_core (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .lim_i(lim), .feed_i(feed),
    .stat_rd_i(stat_rd), .tick_int_i(tick_int_i), .tick_ext_i(tick_ext_i),
    .cnt_o(cnt), .flag_o(flag), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  // R10: an enabled flag shows on irq_o one clock later
  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    (flag && ctrl.irq_en) |=> irq_o);
endmodule

// File: tb/test_apb_watchdog.sv
module test_apb_watchdog;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_PSC = 8'h04, A_CNT = 8'h08,
    A_LIM = 8'h0C, A_STAT = 8'h10, A_KEY = 8'h14, A_FEED = 8'h18;
  localparam logic [31:0] KEYW = 32'h5F37_59DF;

  logic clk = 0, rst = 1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic pready, pslverr, tick_int = 0, tick_ext = 0, irq, sysrst;
  logic [19:0] presc;
  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct { logic [31:0] d; string tag; } exp_t;
  exp_t sb_q[$];

  apb_watchdog i_apb_watchdog (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .tick_int_i(tick_int), .tick_ext_i(tick_ext),
    .presc_o(presc), .irq_o(irq), .sys_rst_o(sysrst)
  );

  always #(CLK_P/2) clk = ~clk;

  // monitor: pops the scoreboard in each read access phase
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (psel && penable && !pwrite) begin
      exp_t e;
      total++;
      if (sb_q.size() == 0) begin
        bad++; $display("FAIL scoreboard empty: got=%h exp=none", prdata);
      end else begin
        e = sb_q.pop_front();
        if (prdata !== e.d) begin
          bad++; $display("FAIL %s: got=%h exp=%h", e.tag, prdata, e.d);
        end
      end
      total++;
      if (pready !== 1'b1 || pslverr !== 1'b0) begin
        bad++; $display("FAIL R1 handshake: got=%b%b exp=10", pready, pslverr);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++; $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.d = exp; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic kwr(input logic [7:0] a, input logic [31:0] d);
    apb_wr(A_KEY, KEYW);
    apb_wr(a, d);
  endtask

  task automatic ticks(input bit ext, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (ext) tick_ext = 1; else tick_int = 1;
      @(negedge clk); tick_ext = 0; tick_int = 0;
    end
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog: got=timeout exp=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R5 reset state
    chk("R5 irq", 32'(irq), 0);
    chk("R5 sys_rst", 32'(sysrst), 0);
    chk("R12 presc reset", 32'(presc), 2);
    apb_rd(A_CTRL, 0, "R5 ctrl");
    apb_rd(A_PSC,  2, "R5 psc");
    apb_rd(A_CNT,  0, "R5 cnt");
    apb_rd(A_LIM,  0, "R5 lim");
    apb_rd(A_STAT, 0, "R5 stat");
    apb_rd(A_FEED, 0, "R5 feed");
    apb_rd(A_KEY,  0, "R1 key reads 0");
    // R3 locked write ignored
    apb_wr(A_CTRL, 32'h5);
    apb_rd(A_CTRL, 0, "R3 locked ctrl");
    // R2 keyed write, R3
    kwr(A_LIM, 3);
    apb_rd(A_LIM, 3, "R2 keyed lim");
    // R2 wrong key arms nothing
    apb_wr(A_KEY, 32'h1234_5678);
    apb_wr(A_PSC, 5);
    apb_rd(A_PSC, 2, "R2 wrong key");
    // R4 write to read-only count spends the lock
    apb_wr(A_KEY, KEYW);
    apb_wr(A_CNT, 32'h77);
    apb_wr(A_PSC, 7);
    apb_rd(A_PSC, 2, "R4 lock spent");
    apb_rd(A_CNT, 0, "R6 cnt ignores write");
    // R1 misaligned write ignored
    apb_wr(A_KEY, KEYW);
    apb_wr(A_PSC | 8'h1, 9);
    apb_wr(A_PSC, 9);
    apb_rd(A_PSC, 9, "R1 misaligned write dropped");
    // R12 masked width
    kwr(A_PSC, 32'hFFFF_FFFF);
    apb_rd(A_PSC, 32'h000F_FFFF, "R12 psc width");
    @(negedge clk);
    chk("R12 presc_o", 32'(presc), 32'h000F_FFFF);
    // R6 internal counting, R7 overflow after lim+1
    kwr(A_CTRL, 32'h5);
    ticks(0, 3);
    apb_rd(A_CNT, 3, "R6 count 3");
    settle();
    chk("R7 no flag yet", 32'(sysrst), 0);
    ticks(0, 1);
    settle();
    chk("R11 sys_rst set", 32'(sysrst), 1);
    chk("R10 irq set", 32'(irq), 1);
    apb_rd(A_CNT, 0, "R7 wrapped");
    apb_rd(A_STAT, 1, "R8 flag read");
    apb_rd(A_STAT, 0, "R8 flag cleared");
    settle();
    chk("R11 sys_rst cleared by read", 32'(sysrst), 0);
    chk("R10 irq cleared", 32'(irq), 0);
    // R6 external source
    kwr(A_CTRL, 32'hFFFF_FFFF);
    apb_rd(A_CTRL, 7, "R1 ctrl reserved");
    ticks(0, 2);
    apb_rd(A_CNT, 0, "R6 int ignored when ext");
    ticks(1, 2);
    apb_rd(A_CNT, 2, "R6 ext counted");
    // R9 feed hold
    kwr(A_FEED, 1);
    ticks(1, 2);
    apb_rd(A_CNT, 0, "R9 held");
    apb_rd(A_FEED, 1, "R9 feed reads 1");
    kwr(A_FEED, 0);
    ticks(1, 1);
    apb_rd(A_CNT, 1, "R9 resumed");
    // R11 feed drops reset but flag stays
    ticks(1, 3);
    settle();
    chk("R11 sys_rst ext", 32'(sysrst), 1);
    kwr(A_FEED, 1);
    settle();
    chk("R11 sys_rst cleared by feed", 32'(sysrst), 0);
    chk("R8 irq kept by flag", 32'(irq), 1);
    apb_rd(A_STAT, 1, "R8 feed keeps flag");
    kwr(A_FEED, 0);
    // R10 masked interrupt
    kwr(A_CTRL, 32'h4);
    ticks(0, 4);
    settle();
    chk("R10 irq masked", 32'(irq), 0);
    chk("R11 sys_rst masked irq", 32'(sysrst), 1);
    kwr(A_CTRL, 0);
    settle();
    chk("R11 sys_rst dropped by disable", 32'(sysrst), 0);
    ticks(0, 2);
    apb_rd(A_CNT, 0, "R6 disabled holds");
    apb_rd(A_STAT, 1, "R7 flag from masked run");
    settle();
    chk("R1 scoreboard drained", 32'(sb_q.size()), 0);
    finish_run();
  end
endmodule